// File: doc/BRIEF.md
# Shared-Select Serial Command Port for a Six-Channel Output Controller

This block is the serial slave port of a six-channel output controller. A host shifts in 16-bit frames, most significant bit first: one instruction byte, then one data byte. Several devices may hang off one chip select. The block claims a frame only when the two leading instruction bits carry its fixed tag. Until then, and for the whole of any frame it does not claim, its serial output stays undriven. Once it claims a frame it shifts back latched fault status or the contents of a register. It also drives the six channel enables. Each channel follows either a parallel input pin or a serial control bit.

Fault inputs arrive as one 2-bit code per channel plus an over-temperature line. Faults are latched and held until a complete diagnostic-read frame has been taken in. The serial inputs are sampled in the system clock domain through a synchronizer, so the serial clock must run well below the system clock.

Top module: `ch6_spi_ctrl`

## Requirements
- R1: While `rst_n` is low, `spi_so_oe` is 0. Reset sets every serial control bit to 1 (off) and every mux bit to 0 (serial), so `ch_en` reads 0.
- R2: `spi_so_oe` stays 0 while the first two bits of a frame are shifted in. It goes to 1 from the third bit on only when instruction bit 7 is 1 and bit 6 is 0.
- R3: When bits 7:6 differ from 1,0, `spi_so_oe` stays 0 for the whole frame, and the frame changes no register and no fault latch.
- R4: In a claimed frame, output bits 5..0 of the instruction byte are: the common fault flag (1 when any latched channel code differs from 2'b11 or the over-temperature latch is set), then the over-temperature latch, then the codes of channel 6 and channel 5, each code most significant bit first.
- R5: For a diagnostic read (instruction bits 5:2 = 0000), a write, or an unknown command, the data byte returns the codes of channels 4 down to 1.
- R6: Command 0101 (read serial control) returns the serial control bits of channels 6..1 in data bits 7:2, followed by two 1 bits.
- R7: Command 1001 (read mux) returns the mux bits of channels 6..1 in data bits 7:2, followed by two 0 bits.
- R8: Command 0110 loads data bits 7:2 as the serial control bits of channels 6..1, where 1 means off.
- R9: Command 1010 loads data bits 7:2 as the mux bits of channels 6..1, where 1 selects the parallel pin.
- R10: A write or a fault clear takes effect when chip select rises, and only if exactly 16 clock edges were counted in the claimed frame.
- R11: An instruction with any other command code leaves both registers unchanged.
- R12: Each channel's latched code holds its first non-2'b11 value, and the over-temperature latch holds a 1, until a complete diagnostic read. At the end of that read the latches take the live input values.
- R13: `ch_en[c]` equals `par_in[c]` when mux bit c is 1, and the inverse of serial control bit c when mux bit c is 0.
- R14: Raising chip select in mid-frame returns the receiver to waiting for a new instruction, and the next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low, sampled on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable of the serial data out pad |
| par_in | input | 6 | Parallel control pins, one per channel |
| flt_code | input | 12 | Live fault code per channel, channel 6 in bits 11:10, 2'b11 means no fault |
| ot_in | input | 1 | Live over-temperature indication |
| ch_en | output | 6 | Channel enables, 1 means on |

## Verification
On every cycle the assertions check four things. The output enable is low throughout reset. It can first rise only at the third counted bit. The two control registers change only in the cycle after chip select is released. The over-temperature latch falls only at a fault clear. Frame content can only be shown by the bench's scenarios: the bit order on the serial output, command decoding, the rejection of foreign and wrong-length frames, and the way sticky fault codes survive until a diagnostic read and then re-capture live values.

// File: rtl/ch6_spi_pkg.sv
package ch6_spi_pkg;
    localparam int NCH        = 6;
    localparam int CODE_W     = 2;
    localparam int CODES_W    = NCH * CODE_W;
    localparam int DIAG_W     = CODES_W + 2;
    localparam int FRAME_BITS = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int BYTE_BITS  = 8;

    localparam logic [1:0]        ADDR_TAG = 2'b10;
    localparam logic [CODE_W-1:0] CODE_OK  = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CLAIM,
        ST_REJECT
    } frm_st_e;

    typedef enum logic [3:0] {
        CMD_RD_DIAG = 4'b0000,
        CMD_RD_SCTL = 4'b0101,
        CMD_WR_SCTL = 4'b0110,
        CMD_RD_MUX  = 4'b1001,
        CMD_WR_MUX  = 4'b1010
    } cmd_e;

    typedef struct packed {
        frm_st_e              st;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_BITS-1:0] rx;
        cmd_e                 cmd;
        logic [DIAG_W-1:0]    snap;
        logic                 cs_prev;
        logic                 sck_prev;
    } frm_t;

    typedef struct packed {
        logic [NCH-1:0] sctl;
        logic [NCH-1:0] mux;
    } regs_t;

    typedef struct packed {
        logic [CODES_W-1:0] code;
        logic               ot;
    } flt_t;
endpackage

// File: rtl/ch6_spi_sync.sv
module ch6_spi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ch6_spi_fault.sv
module ch6_spi_fault
    import ch6_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODES_W-1:0] live_code,
    input  logic               live_ot,
    input  logic               clr,
    output logic [CODES_W-1:0] held_code,
    output logic               held_ot,
    output logic               any_flt
);
    flt_t flt_d, flt_q;
    logic [NCH-1:0] ch_bad;

    always_comb begin
        flt_d = flt_q;
        for (int c = 0; c < NCH; c++) begin
            if (clr || flt_q.code[c*CODE_W +: CODE_W] == CODE_OK) begin
                flt_d.code[c*CODE_W +: CODE_W] = live_code[c*CODE_W +: CODE_W];
            end
        end
        flt_d.ot = clr ? live_ot : (flt_q.ot | live_ot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.code <= {NCH{CODE_OK}};
            flt_q.ot   <= 1'b0;
        end else begin
            flt_q <= flt_d;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_bad
            assign ch_bad[g] = (flt_q.code[g*CODE_W +: CODE_W] != CODE_OK);
        end
    endgenerate

    assign held_code = flt_q.code;
    assign held_ot   = flt_q.ot;
    assign any_flt   = (|ch_bad) | flt_q.ot;
endmodule

// File: rtl/ch6_spi_frame.sv
module ch6_spi_frame
    import ch6_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              si_s,
    input  logic [DIAG_W-1:0] diag_in,
    input  logic [NCH-1:0]    sctl,
    input  logic [NCH-1:0]    mux,
    output logic              so_bit,
    output logic              so_drv,
    output logic              wr_sctl,
    output logic              wr_mux,
    output logic              diag_clr,
    output logic              frm_end,
    output logic [NCH-1:0]    wr_data,
    output logic [CNT_W-1:0]  bit_cnt
);
    frm_t frm_d, frm_q;
    logic cs_act, sck_rise;
    logic [3:0] idx;
    logic [15:0] snap_ext;
    logic [BYTE_BITS-1:0] sctl_byte, mux_byte;

    assign cs_act    = ~cs_n_s;
    assign sck_rise  = sck_s & ~frm_q.sck_prev;
    assign snap_ext  = {{(16-DIAG_W){1'b0}}, frm_q.snap};
    assign sctl_byte = {sctl, 2'b11};
    assign mux_byte  = {mux, 2'b00};

    always_comb begin
        frm_d          = frm_q;
        frm_d.cs_prev  = cs_act;
        frm_d.sck_prev = sck_s;
        wr_sctl        = 1'b0;
        wr_mux         = 1'b0;
        diag_clr       = 1'b0;
        frm_end        = 1'b0;
        if (!cs_act) begin
            if (frm_q.cs_prev) begin
                frm_end = 1'b1;
                if (frm_q.st == ST_CLAIM && frm_q.cnt == CNT_W'(FRAME_BITS)) begin
                    case (frm_q.cmd)
                        CMD_WR_SCTL: wr_sctl  = 1'b1;
                        CMD_WR_MUX:  wr_mux   = 1'b1;
                        CMD_RD_DIAG: diag_clr = 1'b1;
                        default:     ;
                    endcase
                end
            end
            frm_d.st  = ST_IDLE;
            frm_d.cnt = '0;
        end else if (!frm_q.cs_prev) begin
            frm_d.st  = ST_ADDR;
            frm_d.cnt = '0;
            frm_d.rx  = '0;
        end else if (sck_rise && (frm_q.st == ST_ADDR || frm_q.st == ST_CLAIM)) begin
            frm_d.rx = {frm_q.rx[BYTE_BITS-2:0], si_s};
            if (frm_q.cnt < CNT_W'(CNT_MAX)) begin
                frm_d.cnt = frm_q.cnt + 1'b1;
            end
            if (frm_q.st == ST_ADDR && frm_q.cnt == CNT_W'(1)) begin
                if ({frm_q.rx[0], si_s} == ADDR_TAG) begin
                    frm_d.st   = ST_CLAIM;
                    frm_d.snap = diag_in;
                end else begin
                    frm_d.st = ST_REJECT;
                end
            end
            if (frm_q.cnt == CNT_W'(BYTE_BITS - 1)) begin
                frm_d.cmd = cmd_e'(frm_q.rx[4:1]);
            end
        end
    end

    always_comb begin
        idx    = 4'(5'd15 - 5'(frm_q.cnt));
        so_bit = 1'b0;
        if (frm_q.cnt >= CNT_W'(2) && frm_q.cnt < CNT_W'(FRAME_BITS)) begin
            if (frm_q.cnt >= CNT_W'(BYTE_BITS) && frm_q.cmd == CMD_RD_SCTL) begin
                so_bit = sctl_byte[idx[2:0]];
            end else if (frm_q.cnt >= CNT_W'(BYTE_BITS) && frm_q.cmd == CMD_RD_MUX) begin
                so_bit = mux_byte[idx[2:0]];
            end else begin
                so_bit = snap_ext[idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q.st       <= ST_IDLE;
            frm_q.cnt      <= '0;
            frm_q.rx       <= '0;
            frm_q.cmd      <= CMD_RD_DIAG;
            frm_q.snap     <= '0;
            frm_q.cs_prev  <= 1'b0;
            frm_q.sck_prev <= 1'b0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign so_drv  = (frm_q.st == ST_CLAIM);
    assign wr_data = frm_q.rx[BYTE_BITS-1:BYTE_BITS-NCH];
    assign bit_cnt = frm_q.cnt;
endmodule

// File: rtl/ch6_spi_regs.sv
module ch6_spi_regs
    import ch6_spi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_sctl,
    input  logic           wr_mux,
    input  logic [NCH-1:0] wr_data,
    input  logic [NCH-1:0] par_in,
    output logic [NCH-1:0] sctl,
    output logic [NCH-1:0] mux,
    output logic [NCH-1:0] ch_en
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_sctl) regs_d.sctl = wr_data;
        if (wr_mux)  regs_d.mux  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.sctl <= '1;
            regs_q.mux  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_sel
            assign ch_en[g] = regs_q.mux[g] ? par_in[g] : ~regs_q.sctl[g];
        end
    endgenerate

    assign sctl = regs_q.sctl;
    assign mux  = regs_q.mux;
endmodule

// File: rtl/ch6_spi_ctrl.sv
module ch6_spi_ctrl
    import ch6_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_si,
    output logic               spi_so,
    output logic               spi_so_oe,
    input  logic [NCH-1:0]     par_in,
    input  logic [CODES_W-1:0] flt_code,
    input  logic               ot_in,
    output logic [NCH-1:0]     ch_en
);
    logic [2:0]         pins_s;
    logic               so_bit, so_drv;
    logic               wr_sctl, wr_mux, diag_clr, frm_end;
    logic [NCH-1:0]     wr_data, sctl_q, mux_q;
    logic [CNT_W-1:0]   frm_cnt;
    logic [CODES_W-1:0] held_code;
    logic               held_ot, any_flt;

    ch6_spi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sck, spi_si}),
        .q     (pins_s)
    );

    ch6_spi_fault u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_code (flt_code),
        .live_ot   (ot_in),
        .clr       (diag_clr),
        .held_code (held_code),
        .held_ot   (held_ot),
        .any_flt   (any_flt)
    );

    ch6_spi_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (pins_s[1]),
        .cs_n_s   (pins_s[2]),
        .si_s     (pins_s[0]),
        .diag_in  ({any_flt, held_ot, held_code}),
        .sctl     (sctl_q),
        .mux      (mux_q),
        .so_bit   (so_bit),
        .so_drv   (so_drv),
        .wr_sctl  (wr_sctl),
        .wr_mux   (wr_mux),
        .diag_clr (diag_clr),
        .frm_end  (frm_end),
        .wr_data  (wr_data),
        .bit_cnt  (frm_cnt)
    );

    ch6_spi_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sctl (wr_sctl),
        .wr_mux  (wr_mux),
        .wr_data (wr_data),
        .par_in  (par_in),
        .sctl    (sctl_q),
        .mux     (mux_q),
        .ch_en   (ch_en)
    );

    assign spi_so_oe = so_drv & rst_n;
    assign spi_so    = so_bit & spi_so_oe;
endmodule

// File: rtl/ch6_spi_ctrl_chk.sv
module ch6_spi_ctrl_chk
    import ch6_spi_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             so_oe,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [NCH-1:0]   sctl,
    input logic [NCH-1:0]   mux,
    input logic             frm_end,
    input logic             diag_clr,
    input logic             held_ot
);
    always_comb begin
        if (!rst_n) begin
            AST_RST_TRI: assert (!so_oe) else $error("output driven in reset"); // R1
        end
    end

    AST_CLAIM_AT_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> bit_cnt == CNT_W'(2)); // R2

    AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> bit_cnt >= CNT_W'(2)); // R2

    AST_SCTL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (sctl != $past(sctl)) |-> $past(frm_end)); // R8

    AST_MUX_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mux != $past(mux)) |-> $past(frm_end)); // R9

    AST_OT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(held_ot) && !$past(diag_clr)) |-> held_ot); // R12
endmodule

bind ch6_spi_ctrl ch6_spi_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .so_oe    (spi_so_oe),
    .bit_cnt  (frm_cnt),
    .sctl     (sctl_q),
    .mux      (mux_q),
    .frm_end  (frm_end),
    .diag_clr (diag_clr),
    .held_ot  (held_ot)
);

// File: tb/ch6_spi_ctrl_tb.sv
module ch6_spi_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic [5:0]  par = 6'h3F;
    logic [11:0] code = 12'hFFF;
    logic        ot = 1'b0;
    logic        so, so_oe;
    logic [5:0]  en;

    int n_chk = 0;
    int n_bad = 0;

    logic [5:0]  m_sctl = 6'h3F;
    logic [5:0]  m_mux = 6'h00;
    logic [11:0] m_code = 12'hFFF;
    logic        m_ot = 1'b0;

    // entry: {frame16, live code12, live ot, par6}
    localparam logic [34:0] VEC [0:10] = '{
        {16'h9854, 12'hFFF, 1'b0, 6'h3F},
        {16'h9400, 12'hFFF, 1'b0, 6'h00},
        {16'hA8C0, 12'hFFF, 1'b0, 6'h2A},
        {16'hA400, 12'hFFF, 1'b0, 6'h15},
        {16'h80FF, 12'hFDF, 1'b1, 6'h3F},
        {16'h8000, 12'hFFF, 1'b0, 6'h3F},
        {16'hBC00, 12'hFFF, 1'b0, 6'h00},
        {16'h5800, 12'hFFF, 1'b0, 6'h00},
        {16'hD800, 12'hFFF, 1'b0, 6'h00},
        {16'h9800, 12'hFFC, 1'b0, 6'h30},
        {16'h9400, 12'hFFF, 1'b0, 6'h10}
    };

    ch6_spi_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (sck),
        .spi_cs_n  (cs_n),
        .spi_si    (si),
        .spi_so    (so),
        .spi_so_oe (so_oe),
        .par_in    (par),
        .flt_code  (code),
        .ot_in     (ot),
        .ch_en     (en)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // tx is left-aligned: bit i of the frame is tx[23-i]
    task automatic xfer(input logic [23:0] tx, input int nb,
                        output logic [15:0] rxv, output logic [15:0] oev);
        rxv = '0;
        oev = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nb; i++) begin
            si = tx[23-i];
            wait_clk(8);
            if (i < 16) begin
                rxv[15-i] = so;
                oev[15-i] = so_oe;
            end
            sck = 1'b1;
            wait_clk(8);
            sck = 1'b0;
        end
        wait_clk(8);
        cs_n = 1'b1;
        wait_clk(16);
    endtask

    task automatic set_live(input logic [11:0] c, input logic o, input logic [5:0] p);
        code = c;
        ot   = o;
        par  = p;
        wait_clk(6);
        for (int ch = 0; ch < 6; ch++) begin
            if (m_code[2*ch +: 2] == 2'b11) m_code[2*ch +: 2] = c[2*ch +: 2];
        end
        m_ot = m_ot | o;
    endtask

    function automatic logic [15:0] exp_frame(input logic [3:0] cmd);
        logic f;
        logic [15:0] e;
        f = m_ot;
        for (int ch = 0; ch < 6; ch++) begin
            if (m_code[2*ch +: 2] != 2'b11) f = 1'b1;
        end
        e = {2'b00, f, m_ot, m_code};
        if (cmd == 4'b0101) e[7:0] = {m_sctl, 2'b11};
        if (cmd == 4'b1001) e[7:0] = {m_mux, 2'b00};
        return e;
    endfunction

    function automatic string tag_of(input logic [3:0] cmd);
        case (cmd)
            4'b0101: return "R6 R4 read-sctl";
            4'b1001: return "R7 R4 read-mux";
            4'b0110: return "R8 R5 write-sctl";
            4'b1010: return "R9 R5 write-mux";
            4'b0000: return "R12 R5 R4 read-diag";
            default: return "R11 R5 unknown";
        endcase
    endfunction

    // run one full 16-bit frame and check it against the model
    task automatic run_frame(input logic [15:0] tx, input string extra);
        logic [15:0] rxv, oev, e, mask;
        logic [3:0]  cmd;
        logic        hit;
        cmd  = tx[13:10];
        hit  = (tx[15:14] == 2'b10);
        e    = exp_frame(cmd);
        mask = hit ? 16'h3FFF : 16'h0000;
        xfer({tx, 8'h00}, 16, rxv, oev);
        chk(oev == mask, hit ? {"R2 oe ", extra} : {"R3 oe ", extra}, oev, mask);
        if (hit) begin
            chk((rxv & mask) == e, {tag_of(cmd), " ", extra}, rxv & mask, e);
            case (cmd)
                4'b0110: m_sctl = tx[7:2];
                4'b1010: m_mux  = tx[7:2];
                4'b0000: begin m_code = code; m_ot = ot; end
                default: ;
            endcase
        end
    endtask

    task automatic chk_en(input string tag);
        logic [5:0] e;
        e = (m_mux & par) | (~m_mux & ~m_sctl);
        chk(en == e, tag, {10'h0, en}, {10'h0, e});
    endtask

    initial begin
        logic [15:0] rxv, oev;
        wait_clk(5);
        // R1: reset state while reset is held
        chk(so_oe == 1'b0, "R1 oe in reset", {15'h0, so_oe}, 16'h0);
        chk(en == 6'h00, "R1 ch_en in reset", {10'h0, en}, 16'h0);
        rst_n = 1'b1;
        wait_clk(5);
        // R1: register reset values read back
        run_frame(16'h9400, "R1 reset sctl");
        run_frame(16'hA400, "R1 reset mux");

        for (int k = 0; k < 11; k++) begin
            set_live(VEC[k][18:7], VEC[k][6], VEC[k][5:0]);
            run_frame(VEC[k][34:19], $sformatf("vec%0d", k));
            chk_en($sformatf("R13 ch_en vec%0d", k));
        end

        // R13: parallel pins followed on channels in parallel mode
        set_live(12'hFFF, 1'b0, 6'h20);
        chk_en("R13 par 20");
        set_live(12'hFFF, 1'b0, 6'h10);
        chk_en("R13 par 10");

        // R10: short and long frames write nothing
        xfer({16'h98FC, 8'h00}, 15, rxv, oev);
        run_frame(16'h9400, "R10 after 15-bit write");
        xfer({16'h98FC, 8'h00}, 17, rxv, oev);
        run_frame(16'h9400, "R10 after 17-bit write");

        // R14: abort after five bits, next frame decodes cleanly
        xfer({16'hA8FC, 8'h00}, 5, rxv, oev);
        run_frame(16'hA400, "R14 after abort");
        run_frame(16'h9400, "R14 sctl after abort");

        // R12: fault held over a write, cleared only by diag read
        set_live(12'h3FF, 1'b1, 6'h00);
        set_live(12'hFFF, 1'b0, 6'h00);
        run_frame(16'h9854, "R12 write keeps latch");
        run_frame(16'h8000, "R12 diag read shows held");
        run_frame(16'h8000, "R12 cleared");

        // R3: foreign diag read does not clear latch
        set_live(12'hFF3, 1'b0, 6'h00);
        set_live(12'hFFF, 1'b0, 6'h00);
        run_frame(16'h0000, "R3 foreign diag");
        run_frame(16'h8000, "R3 latch kept");

        // R1: reset in mid-frame releases the output at once
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < 4; i++) begin
            si = (i == 0);
            wait_clk(8);
            sck = 1'b1;
            wait_clk(8);
            sck = 1'b0;
        end
        chk(so_oe == 1'b1, "R2 claimed before reset", {15'h0, so_oe}, 16'h1);
        rst_n = 1'b0;
        #1;
        chk(so_oe == 1'b0, "R1 oe on reset", {15'h0, so_oe}, 16'h0);
        cs_n = 1'b1;
        par  = 6'h3F;
        wait_clk(4);
        m_sctl = 6'h3F; m_mux = 6'h00; m_code = 12'hFFF; m_ot = 1'b0;
        chk(en == 6'h00, "R1 ch_en after reset", {10'h0, en}, 16'h0);
        rst_n = 1'b1;
        wait_clk(4);
        run_frame(16'h9400, "R1 sctl after reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule